// File: doc/BRIEF.md
# I2C Event Status and Stretch Controller

This block collects the event indications of an I2C peripheral into two CPU-readable status registers and one summary event bit. The byte engine reports each bus event with a one-cycle strobe. The block latches each strobe into a sticky flag and raises an interrupt request when interrupts are enabled. It also tells the byte engine when the serial clock line must be held low and when the transfer has to pause for software.

Reading a status register clears the event flags that belong to that register. A strobe that lands in the same cycle as such a read is returned in the read data. That same read then drops it, so no interrupt is raised for it. Clearing the peripheral-enable bit wipes all flags and the interrupt enable. The shifter, the start/stop detector and the bit-rate generator sit outside the block and are modelled as stimulus.

Top module: `i2c_evt_stat_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), stat1_o, stat2_o, ie_o, irq_o, stretch_o and suspend_o are all 0.
- R2: stat1_o bit 5 is the registered tra_i, bit 4 is the registered busy_i and bit 1 is the registered master_i. A register read never clears these three bits.
- R3: A strobe on evt_i[k] with pe_i=1 sets its flag at the next clock edge. The indices are: 0 start sent, 1 address matched, 2 byte done, 3 header sent, 4 address sent, 5 no-acknowledge, 6 stop seen, 7 arbitration lost, 8 bus error. stat1_o packs {evf, hdr, tra, busy, byte, addr-match, master, start} from bit 7 down to bit 0. stat2_o packs {000, buserr, arblost, stop, nack, addrsent}. evf (stat1_o bit 7) is the OR of all nine flags.
- R4: A strobe on evt_i[1] (address matched) is ignored while ack_en_i is 0.
- R5: rd_en_i with rd_sel_i=0 returns stat1 on rd_data_o and clears flags 0 to 3 at the clock edge. rd_sel_i=1 returns stat2 and clears flags 4 to 8. evf falls only when all nine flags are clear. rd_data_o is 0 when rd_en_i is 0.
- R6: A strobe that arrives in the same cycle as a read that clears its flag shows in rd_data_o, including the evf bit. The flag is not set afterwards, and no interrupt is raised for it.
- R7: A strobe that arrives in the same cycle as a read of the other register is latched. It raises irq_o at that clock edge.
- R8: While pe_i is 0, all flags, evf and ie_o are cleared at each clock edge, and strobes and interrupt-enable writes are ignored.
- R9: ie_o is loaded from ie_wdata_i when ie_wr_i is 1. irq_o is a register equal to ie_o AND evf.
- R10: stretch_o is registered one cycle after the flags. It is 1 when any of flags 0 to 4 is set, or when dma_en_i is 1 and dma_done_i is 0.
- R11: suspend_o is registered one cycle after the flags. It is 1 when any flag other than byte done is set, or when byte done is set while dma_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_i | input | 1 | Peripheral enable |
| ack_en_i | input | 1 | Acknowledge enable; gates the address-match event |
| ie_wr_i | input | 1 | Write strobe for the interrupt enable |
| ie_wdata_i | input | 1 | Value written to the interrupt enable |
| dma_en_i | input | 1 | DMA enabled |
| dma_done_i | input | 1 | DMA transfer complete |
| evt_i | input | 9 | Event strobes, indices as in R3 |
| tra_i | input | 1 | Live transmitter state |
| busy_i | input | 1 | Live bus-busy state |
| master_i | input | 1 | Live master state |
| rd_en_i | input | 1 | CPU status read strobe |
| rd_sel_i | input | 1 | 0 reads stat1, 1 reads stat2 |
| rd_data_o | output | 8 | Read data |
| stat1_o | output | 8 | Status register 1 |
| stat2_o | output | 8 | Status register 2 |
| ie_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| stretch_o | output | 1 | Hold serial clock low |
| suspend_o | output | 1 | Transfer suspended |

## Verification
The block has no size parameters; the bench builds it with the nine-event default. At that size every one of the 512 event combinations can be swept against all four DMA enable/done settings. Each pass checks the register packing, the summary bit, the interrupt, stretch and suspend. It also checks the two-step read clearing, register by register. Directed sequences then cover the address-match gate, reads that race a strobe, disable and the interrupt-enable path.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int REG_W = 8;
  localparam int N_EVT = 9;

  localparam int EV_SB    = 0;
  localparam int EV_ADSL  = 1;
  localparam int EV_BTF   = 2;
  localparam int EV_HDR   = 3;
  localparam int EV_ADDTX = 4;
  localparam int EV_NACK  = 5;
  localparam int EV_STOP  = 6;
  localparam int EV_ARB   = 7;
  localparam int EV_BERR  = 8;

  localparam logic [N_EVT-1:0] GRP1_MASK = 9'b0_0000_1111;
  localparam logic [N_EVT-1:0] GRP2_MASK = 9'b1_1111_0000;
  localparam logic [N_EVT-1:0] HOLD_MASK = 9'b0_0001_1111;
  localparam logic [N_EVT-1:0] BTF_BIT   = 9'b0_0000_0100;

  function automatic logic [REG_W-1:0] pack_sr1(input logic evf, input logic [N_EVT-1:0] f,
                                               input logic tra, input logic busy, input logic mst);
    pack_sr1 = {evf, f[EV_HDR], tra, busy, f[EV_BTF], f[EV_ADSL], mst, f[EV_SB]};
  endfunction

  function automatic logic [REG_W-1:0] pack_sr2(input logic [N_EVT-1:0] f);
    pack_sr2 = {3'b000, f[EV_BERR], f[EV_ARB], f[EV_STOP], f[EV_NACK], f[EV_ADDTX]};
  endfunction

  function automatic logic need_hold(input logic [N_EVT-1:0] f, input logic dma_en,
                                     input logic dma_done);
    need_hold = (|(f & HOLD_MASK)) | (dma_en & ~dma_done);
  endfunction

  function automatic logic need_suspend(input logic [N_EVT-1:0] f, input logic dma_en);
    need_suspend = (|(f & ~BTF_BIT)) | (f[EV_BTF] & ~dma_en);
  endfunction
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = i2c_evt_pkg::N_EVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pe_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a set racing a clearing read is swallowed
    assign nxt_o[i] = pe_i & (q[i] | set_i[i]) & ~clr_i[i];

    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt_o[i];
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_i && q[i] && !clr_i[i]) |=> q[i]); // R3
    AST_FLAG_RACE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && clr_i[i] && !q[i]) |=> !q[i]); // R6
  end

  assign q_o = q;

  AST_FLAG_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_i |=> (q == '0)); // R8
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pe_i,
  input  logic ie_wr_i,
  input  logic ie_wdata_i,
  input  logic evf_nxt_i,
  output logic ie_o,
  output logic irq_o
);
  logic ie_q, irq_q, ie_nxt;

  assign ie_nxt = pe_i & (ie_wr_i ? ie_wdata_i : ie_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_nxt;
      irq_q <= ie_nxt & evf_nxt_i;
    end
  end

  assign ie_o  = ie_q;
  assign irq_o = irq_q;

  AST_IE_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_i |=> (!ie_o && !irq_o)); // R8
  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_i && ie_wr_i) |=> (ie_o == $past(ie_wdata_i))); // R9
endmodule

// File: rtl/evt_hold_ctrl.sv
module evt_hold_ctrl #(
  parameter int N = i2c_evt_pkg::N_EVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic         dma_en_i,
  input  logic         dma_done_i,
  output logic         stretch_o,
  output logic         suspend_o
);
  import i2c_evt_pkg::*;

  logic stretch_q, suspend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stretch_q <= 1'b0;
      suspend_q <= 1'b0;
    end else begin
      stretch_q <= need_hold(flags_i, dma_en_i, dma_done_i);
      suspend_q <= need_suspend(flags_i, dma_en_i);
    end
  end

  assign stretch_o = stretch_q;
  assign suspend_o = suspend_q;

  AST_STRETCH_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en_i && !dma_done_i) |=> stretch_o); // R10
  AST_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i[EV_SB] |=> stretch_o); // R10
  AST_SUSPEND_BTF_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i == BTF_BIT) && dma_en_i) |=> !suspend_o); // R11
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i == '0) |=> !suspend_o); // R11
endmodule

// File: rtl/i2c_evt_stat_ctrl.sv
module i2c_evt_stat_ctrl
  import i2c_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pe_i,
  input  logic             ack_en_i,
  input  logic             ie_wr_i,
  input  logic             ie_wdata_i,
  input  logic             dma_en_i,
  input  logic             dma_done_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             tra_i,
  input  logic             busy_i,
  input  logic             master_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [REG_W-1:0] stat1_o,
  output logic [REG_W-1:0] stat2_o,
  output logic             ie_o,
  output logic             irq_o,
  output logic             stretch_o,
  output logic             suspend_o
);
  logic [N_EVT-1:0] set_vec, clr_vec, flags_q, flags_nxt, view;
  logic             evf_q, evf_nxt;
  logic             tra_q, busy_q, mst_q;

  // address match only counts while acknowledging is enabled
  always_comb begin
    set_vec          = pe_i ? evt_i : '0;
    set_vec[EV_ADSL] = pe_i & ack_en_i & evt_i[EV_ADSL];
  end

  assign clr_vec = rd_en_i ? (rd_sel_i ? GRP2_MASK : GRP1_MASK) : '0;
  assign evf_nxt = |flags_nxt;

  evt_flag_bank #(.N(N_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .pe_i  (pe_i),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (flags_q),
    .nxt_o (flags_nxt)
  );

  evt_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pe_i       (pe_i),
    .ie_wr_i    (ie_wr_i),
    .ie_wdata_i (ie_wdata_i),
    .evf_nxt_i  (evf_nxt),
    .ie_o       (ie_o),
    .irq_o      (irq_o)
  );

  evt_hold_ctrl #(.N(N_EVT)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_i    (flags_q),
    .dma_en_i   (dma_en_i),
    .dma_done_i (dma_done_i),
    .stretch_o  (stretch_o),
    .suspend_o  (suspend_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evf_q  <= 1'b0;
      tra_q  <= 1'b0;
      busy_q <= 1'b0;
      mst_q  <= 1'b0;
    end else begin
      evf_q  <= evf_nxt;
      tra_q  <= tra_i;
      busy_q <= busy_i;
      mst_q  <= master_i;
    end
  end

  // read data shows strobes landing in the read cycle
  assign view = flags_q | set_vec;

  always_comb begin
    if (!rd_en_i)      rd_data_o = '0;
    else if (rd_sel_i) rd_data_o = pack_sr2(view);
    else               rd_data_o = pack_sr1(|view, view, tra_q, busy_q, mst_q);
  end

  assign stat1_o = pack_sr1(evf_q, flags_q, tra_q, busy_q, mst_q);
  assign stat2_o = pack_sr2(flags_q);

  AST_EVF_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    evf_q == (|flags_q)); // R3
  AST_IRQ_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ie_o && stat1_o[7])); // R9
  AST_ADSL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_en_i && !flags_q[EV_ADSL]) |=> !flags_q[EV_ADSL]); // R4
  AST_RD1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_sel_i) |=> (stat1_o[3:2] == 2'b00 && !stat1_o[0] && !stat1_o[6])); // R5
  AST_RD2_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i) |=> (stat2_o == '0)); // R5
  AST_LIVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (stat1_o[5] == $past(tra_i) && stat1_o[4] == $past(busy_i))); // R2
endmodule

// File: tb/i2c_evt_stat_ctrl_tb.sv
module i2c_evt_stat_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic pe = 0, ack_en = 0, ie_wr = 0, ie_wd = 0, dma_en = 0, dma_done = 0;
  logic [8:0] evt = '0;
  logic tra = 0, busy = 0, mst = 0, rd_en = 0, rd_sel = 0;
  logic [7:0] rd_data, stat1, stat2;
  logic ie, irq, stretch, suspend;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_evt_stat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pe_i(pe), .ack_en_i(ack_en), .ie_wr_i(ie_wr),
    .ie_wdata_i(ie_wd), .dma_en_i(dma_en), .dma_done_i(dma_done), .evt_i(evt),
    .tra_i(tra), .busy_i(busy), .master_i(mst), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .stat1_o(stat1), .stat2_o(stat2), .ie_o(ie), .irq_o(irq),
    .stretch_o(stretch), .suspend_o(suspend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e1(input logic [8:0] m, input logic t, input logic b, input logic s);
    e1 = 8'h00;
    e1[7] = (m != 0); e1[6] = m[3]; e1[5] = t; e1[4] = b;
    e1[3] = m[2]; e1[2] = m[1]; e1[1] = s; e1[0] = m[0];
  endfunction

  function automatic logic [7:0] e2(input logic [8:0] m);
    e2 = {3'b000, m[8:4]};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 stat1", stat1, 0); chk("R1 stat2", stat2, 0); chk("R1 ie", ie, 0);
    chk("R1 irq", irq, 0); chk("R1 stretch", stretch, 0); chk("R1 suspend", suspend, 0);
    rst_n = 1; pe = 1; ack_en = 1; ie_wr = 1; ie_wd = 1;
    step(); ie_wr = 0;
    chk("R9 ie load", ie, 1);

    // exhaustive sweep of event combinations and DMA settings
    for (int m = 0; m < 512; m++) begin
      for (int d = 0; d < 4; d++) begin
        logic [8:0] mv;
        logic t, b, s, de, dd, hold, susp;
        mv = m[8:0]; t = m[0]; b = m[1]; s = m[2]; de = d[0]; dd = d[1];
        tra = t; busy = b; mst = s; dma_en = de; dma_done = dd; evt = mv;
        step(); evt = '0;
        chk("R3 stat1", stat1, e1(mv, t, b, s));
        chk("R3 stat2", stat2, e2(mv));
        chk("R9 irq", irq, mv != 0);
        step();
        hold = (mv[4:0] != 0) || (de && !dd);
        susp = ((mv & 9'h1FB) != 0) || (mv[2] && !de);
        chk("R10 stretch", stretch, hold);
        chk("R11 suspend", suspend, susp);
        rd_en = 1; rd_sel = 0;
        #1 chk("R5 rd stat1", rd_data, e1(mv, t, b, s));
        step(); rd_sel = 1;
        chk("R5 grp1 cleared", stat1, e1(mv & 9'h1F0, t, b, s));
        chk("R7 irq after rd1", irq, (mv & 9'h1F0) != 0);
        #1 chk("R5 rd stat2", rd_data, e2(mv));
        step(); rd_en = 0;
        chk("R5 grp2 cleared", stat2, 0);
        chk("R2 live kept", stat1, e1(9'h0, t, b, s));
        chk("R5 irq clear", irq, 0);
        #1 chk("R5 rd idle", rd_data, 0);
      end
    end
    tra = 0; busy = 0; mst = 0; dma_en = 0; dma_done = 0;
    step();

    // R4: address match ignored without ack enable
    ack_en = 0; evt = 9'h002;
    step(); evt = '0; ack_en = 1;
    chk("R4 adsl ignored", stat1, 8'h00);
    chk("R4 no irq", irq, 0);

    // R6: strobe racing a clearing read
    rd_en = 1; rd_sel = 0; evt = 9'h001;
    #1 chk("R6 rd shows sb", rd_data, 8'h81);
    step(); rd_en = 0; evt = '0;
    chk("R6 sb swallowed", stat1, 8'h00);
    chk("R6 no irq", irq, 0);

    // R7: strobe during read of the other register
    rd_en = 1; rd_sel = 1; evt = 9'h001;
    step(); rd_en = 0; evt = '0;
    chk("R7 sb latched", stat1, 8'h81);
    chk("R7 irq raised", irq, 1);

    // R8: disable clears and ignores
    pe = 0; step();
    chk("R8 flags cleared", stat1, 8'h00);
    chk("R8 ie cleared", ie, 0);
    chk("R8 irq cleared", irq, 0);
    evt = 9'h1FF; ie_wr = 1; ie_wd = 1;
    step(); evt = '0; ie_wr = 0;
    chk("R8 strobes ignored", {stat1, stat2}, 16'h0);
    chk("R8 ie write ignored", ie, 0);
    pe = 1; step();

    // R9: pending event with ie off, then enable
    evt = 9'h020; step(); evt = '0;
    chk("R9 evf set", stat1[7], 1);
    chk("R9 irq masked", irq, 0);
    ie_wr = 1; ie_wd = 1; step(); ie_wr = 0;
    chk("R9 irq enabled", irq, 1);
    ie_wr = 1; ie_wd = 0; step(); ie_wr = 0;
    chk("R9 irq disabled", irq, 0);

    // R1: reset mid-activity
    rst_n = 0; step();
    chk("R1 reset stat2", stat2, 0); chk("R1 reset ie", ie, 0);
    chk("R1 reset stretch", stretch, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule